// File: doc/BRIEF.md
# eMMC Boot Acknowledge Monitor

This block watches the single data line of an eMMC card while the card streams its boot partition. Software starts a boot with a one-cycle pulse. It chooses whether the card is expected to send a three-bit acknowledge token before the data. The monitor then reports what it sees on the line through sticky interrupt flags: a valid acknowledge, the first data start bit, framing faults on the start or end bit of a block, a missing first block, and an over-long gap between blocks. Each flag stays set until software clears it with a one-cycle pulse on the matching clear input.

A corrupt acknowledge only withholds the acknowledge flag. The monitor still looks for the first block, still raises the data-start flag and still delivers every received byte. Whether to give up is left to software, which can use the abort input. Data bytes come out one at a time on a byte port with a one-cycle strobe. The line is only looked at on cycles where the card clock enable is high, and both timeouts count those cycles only.

Top module: `emmc_boot_monitor`

## Requirements
- R1: After reset, all six flags on `irq` are 0, `rx_valid` is 0 and the monitor is idle.
- R2: With `expect_ack` high at the boot pulse, the monitor waits for at least one high sample and then a low start bit. It takes the next three samples as the token bits and the sample after them as the end bit. It sets `irq[0]` only if the token bits are 0, 1, 0 in line order and the end bit is 1.
- R3: After the token, whether it was good or bad, the first data start bit sets `irq[1]`. The block that follows is received normally. In a boot without a token, the first data start bit also sets `irq[1]`.
- R4: A data block is a low start bit, then `BLOCK_BYTES` bytes sent MSB first, then an end bit. Each byte appears on `rx_byte`, and `rx_valid` is high for exactly one cycle, in the cycle right after the edge that sampled the byte's last bit.
- R5: A low end bit on a data block sets `irq[3]`. The bytes of that block are still delivered.
- R6: In the wait before each data block, a start bit is accepted only after a high sample. If the first sample of that wait is low, `irq[2]` is set.
- R7: In a boot without a token, if `boot_timeout` = T is nonzero and the T-th sampled cycle of the first wait passes without a start bit, `irq[4]` is set. The monitor then goes idle and ignores the line until the next boot pulse. T = 0 disables this timeout.
- R8: Between blocks, if `gap_timeout` = G is nonzero and G sampled cycles pass without a start bit, `irq[5]` is set. The monitor keeps waiting, restarts the count, and still accepts a later block.
- R9: Cycles with `sample_en` low change no flag and emit no byte, and the timeouts do not count them. In a boot with a token there is no first-block timeout.
- R10: A set flag stays set until `irq_clr` has a 1 at its position. The clear takes effect at the next edge, and only on that bit. A set event in the same cycle wins over the clear.
- R11: `abort` returns the monitor to idle at the next edge from any state. A partly received byte is dropped and never emitted, and all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Synchronous return to idle |
| boot_start | input | 1 | One-cycle pulse that starts a boot watch (only acted on when idle) |
| expect_ack | input | 1 | Latched at `boot_start`: 1 means an acknowledge token comes first |
| sample_en | input | 1 | Card clock enable; the line is sampled only when high |
| dat_in | input | 1 | Serial card data line |
| boot_timeout | input | TO_W | Sampled cycles allowed before the first block in a boot without a token (0 = off) |
| gap_timeout | input | TO_W | Sampled cycles allowed between blocks (0 = off) |
| irq_clr | input | 6 | Write-one-to-clear pulses, one per flag |
| irq | output | 6 | Sticky flags: [0] ack good, [1] data start, [2] start-bit error, [3] end-bit error, [4] first-block timeout, [5] inter-block timeout |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |

## Verification
The bench builds the monitor with `BLOCK_BYTES` = 2 and `TO_W` = 8. Two-byte blocks make each framing case short enough that every one of the eight token patterns can be tried with both end-bit values. They also let all 256 byte values pass through in one boot. The narrow timeout width makes it practical to step each timeout exactly to its limit for several small limits. The bench checks that the flag is still clear one sampled cycle before the limit and set on the limit itself.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ACK_WAIT = 3'd1,
        ST_ACK_BITS = 3'd2,
        ST_ACK_END  = 3'd3,
        ST_BLK_WAIT = 3'd4,
        ST_DATA     = 3'd5,
        ST_DATA_END = 3'd6
    } mon_state_e;

    localparam int IRQ_N    = 6;
    localparam int IRQ_ACK  = 0;
    localparam int IRQ_BDS  = 1;
    localparam int IRQ_SBE  = 2;
    localparam int IRQ_EBE  = 3;
    localparam int IRQ_BTO  = 4;
    localparam int IRQ_DRTO = 5;

    localparam int BYTE_BITS = 8;
    localparam int ACK_BITS  = 3;
    localparam logic [ACK_BITS-1:0] ACK_PATTERN = 3'b010;

endpackage

// File: rtl/emmc_boot_wait_timer.sv
module emmc_boot_wait_timer #(
    parameter int TO_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_zero,
    input  logic            tick,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);

    logic [TO_W-1:0] cnt_d, cnt_q;
    logic [TO_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{TO_W{1'b0}}, 1'b1};
        expire  = tick && !hold_zero && (limit != '0) && (cnt_inc == {1'b0, limit});
        cnt_d   = cnt_q;
        if (hold_zero || expire) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_inc[TO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/emmc_boot_deser.sv
module emmc_boot_deser
    import emmc_boot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift,
    input  logic                 bit_in,
    output logic                 byte_done,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 rx_valid
);

    localparam int BIT_CW = $clog2(BYTE_BITS);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_BITS - 1);

    typedef struct packed {
        logic [BYTE_BITS-1:0] sh;
        logic [BIT_CW-1:0]    bcnt;
        logic [BYTE_BITS-1:0] out;
        logic                 valid;
    } deser_regs_t;

    deser_regs_t r_d, r_q;
    logic [BYTE_BITS-1:0] sh_next;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        sh_next   = {r_q.sh[BYTE_BITS-2:0], bit_in};
        byte_done = shift && (r_q.bcnt == LAST_BIT);
        if (clear) begin
            r_d.sh   = '0;
            r_d.bcnt = '0;
        end else if (shift) begin
            r_d.sh = sh_next;
            if (byte_done) begin
                r_d.bcnt  = '0;
                r_d.out   = sh_next;
                r_d.valid = 1'b1;
            end else begin
                r_d.bcnt = r_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_byte  = r_q.out;
    assign rx_valid = r_q.valid;

endmodule

// File: rtl/emmc_boot_irq_bank.sv
module emmc_boot_irq_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        assign flag_d[i] = set[i] | (flag_q[i] & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/emmc_boot_monitor.sv
module emmc_boot_monitor
    import emmc_boot_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    parameter int TO_W        = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 abort,
    input  logic                 boot_start,
    input  logic                 expect_ack,
    input  logic                 sample_en,
    input  logic                 dat_in,
    input  logic [TO_W-1:0]      boot_timeout,
    input  logic [TO_W-1:0]      gap_timeout,
    input  logic [IRQ_N-1:0]     irq_clr,
    output logic [IRQ_N-1:0]     irq,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 rx_valid
);

    localparam int BC_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
    localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(BLOCK_BYTES - 1);
    localparam logic [1:0] LAST_ACK_BIT = 2'(ACK_BITS - 1);

    typedef struct packed {
        mon_state_e           state;
        logic                 ack_mode;
        logic                 first_blk;
        logic                 seen_high;
        logic                 first_smp;
        logic [1:0]           ack_cnt;
        logic [ACK_BITS-1:0]  ack_pat;
        logic [BC_W-1:0]      byte_cnt;
    } mon_regs_t;

    mon_regs_t r_d, r_q;

    logic [IRQ_N-1:0] irq_set;
    logic             start_ok;
    logic             timer_tick;
    logic             timer_hold;
    logic             timer_hit;
    logic [TO_W-1:0]  timer_limit;
    logic             sh_clear;
    logic             sh_shift;
    logic             byte_done;

    // A qualified start bit: low sample after an idle-high sample.
    assign start_ok    = sample_en && !dat_in && r_q.seen_high;
    assign timer_hold  = (r_q.state != ST_BLK_WAIT);
    assign timer_limit = r_q.first_blk ? boot_timeout : gap_timeout;
    assign timer_tick  = sample_en && !abort && (r_q.state == ST_BLK_WAIT) && !start_ok
                         && !(r_q.first_blk && r_q.ack_mode);
    assign sh_clear    = (r_q.state != ST_DATA);
    assign sh_shift    = sample_en && !abort && (r_q.state == ST_DATA);

    emmc_boot_wait_timer #(
        .TO_W (TO_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (timer_hold),
        .tick      (timer_tick),
        .limit     (timer_limit),
        .expire    (timer_hit)
    );

    emmc_boot_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .shift     (sh_shift),
        .bit_in    (dat_in),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid)
    );

    emmc_boot_irq_bank #(
        .N (IRQ_N)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (irq_clr),
        .flags (irq)
    );

    always_comb begin
        r_d     = r_q;
        irq_set = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (boot_start) begin
                    r_d.ack_mode  = expect_ack;
                    r_d.first_blk = 1'b1;
                    r_d.seen_high = 1'b0;
                    r_d.first_smp = 1'b1;
                    r_d.ack_cnt   = '0;
                    r_d.byte_cnt  = '0;
                    r_d.state     = expect_ack ? ST_ACK_WAIT : ST_BLK_WAIT;
                end
            end

            ST_ACK_WAIT: begin
                if (sample_en) begin
                    if (dat_in) begin
                        r_d.seen_high = 1'b1;
                    end else if (r_q.seen_high) begin
                        r_d.ack_cnt = '0;
                        r_d.state   = ST_ACK_BITS;
                    end
                end
            end

            ST_ACK_BITS: begin
                if (sample_en) begin
                    r_d.ack_pat = {r_q.ack_pat[ACK_BITS-2:0], dat_in};
                    r_d.ack_cnt = r_q.ack_cnt + 2'd1;
                    if (r_q.ack_cnt == LAST_ACK_BIT) begin
                        r_d.state = ST_ACK_END;
                    end
                end
            end

            ST_ACK_END: begin
                if (sample_en) begin
                    irq_set[IRQ_ACK] = dat_in && (r_q.ack_pat == ACK_PATTERN);
                    r_d.seen_high    = 1'b0;
                    r_d.first_smp    = 1'b1;
                    r_d.state        = ST_BLK_WAIT;
                end
            end

            ST_BLK_WAIT: begin
                if (sample_en) begin
                    r_d.first_smp = 1'b0;
                    if (dat_in) begin
                        r_d.seen_high = 1'b1;
                    end else if (start_ok) begin
                        irq_set[IRQ_BDS] = r_q.first_blk;
                        r_d.first_blk    = 1'b0;
                        r_d.byte_cnt     = '0;
                        r_d.state        = ST_DATA;
                    end else if (r_q.first_smp) begin
                        irq_set[IRQ_SBE] = 1'b1;
                    end
                end
                if (timer_hit) begin
                    if (r_q.first_blk) begin
                        irq_set[IRQ_BTO] = 1'b1;
                        r_d.state        = ST_IDLE;
                    end else begin
                        irq_set[IRQ_DRTO] = 1'b1;
                    end
                end
            end

            ST_DATA: begin
                if (byte_done) begin
                    if (r_q.byte_cnt == LAST_BYTE) begin
                        r_d.state = ST_DATA_END;
                    end else begin
                        r_d.byte_cnt = r_q.byte_cnt + 1'b1;
                    end
                end
            end

            ST_DATA_END: begin
                if (sample_en) begin
                    irq_set[IRQ_EBE] = !dat_in;
                    r_d.seen_high    = 1'b0;
                    r_d.first_smp    = 1'b1;
                    r_d.state        = ST_BLK_WAIT;
                end
            end

            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        if (abort) begin
            r_d       = r_q;
            r_d.state = ST_IDLE;
            irq_set   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/emmc_boot_monitor_chk.sv
module emmc_boot_monitor_chk
    import emmc_boot_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             abort,
    input logic             sample_en,
    input logic [IRQ_N-1:0] irq_clr,
    input logic [IRQ_N-1:0] irq,
    input logic             rx_valid
);

    // R4: a byte strobe never lasts two cycles
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11: an abort never lets a byte out
    a_r11_abort_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !rx_valid);

    // R9: unsampled cycles raise no flag
    a_r9_no_flag_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ((irq & ~$past(irq)) == '0));

    // R9: unsampled cycles emit no byte
    a_r9_no_byte_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> !rx_valid);

    for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
        // R10: flags hold without a clear
        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && !irq_clr[i]) |=> irq[i]);

        // R10: a clear on a quiet cycle drops the flag
        a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && irq_clr[i] && !sample_en) |=> !irq[i]);
    end

endmodule

bind emmc_boot_monitor emmc_boot_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .sample_en (sample_en),
    .irq_clr   (irq_clr),
    .irq       (irq),
    .rx_valid  (rx_valid)
);

// File: tb/emmc_boot_monitor_test.sv
`timescale 1ns/1ps
module emmc_boot_monitor_test;

    localparam int NB = 2;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          abort = 1'b0;
    logic          boot_start = 1'b0;
    logic          expect_ack = 1'b0;
    logic          sample_en = 1'b0;
    logic          dat_in = 1'b1;
    logic [TW-1:0] boot_timeout = '0;
    logic [TW-1:0] gap_timeout = '0;
    logic [5:0]    irq_clr = '0;
    logic [5:0]    irq;
    logic [7:0]    rx_byte;
    logic          rx_valid;

    int checks = 0;
    int fails = 0;
    int rx_n = 0;
    logic [7:0] rxq [0:511];
    bit done = 1'b0;

    emmc_boot_monitor #(.BLOCK_BYTES(NB), .TO_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .abort(abort), .boot_start(boot_start),
        .expect_ack(expect_ack), .sample_en(sample_en), .dat_in(dat_in),
        .boot_timeout(boot_timeout), .gap_timeout(gap_timeout),
        .irq_clr(irq_clr), .irq(irq), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (rx_valid && rx_n < 512) begin
            rxq[rx_n] = rx_byte;
            rx_n++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit ce, input bit d);
        sample_en = ce;
        dat_in = d;
        @(posedge clk);
        #1;
        boot_start = 1'b0;
        abort = 1'b0;
        irq_clr = '0;
        sample_en = 1'b0;
    endtask

    task automatic bitv(input bit d);
        cyc(1'b1, d);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bitv(b[i]);
    endtask

    task automatic send_block(input logic [7:0] b0, input logic [7:0] b1, input bit e);
        bitv(1'b0);
        send_byte(b0);
        send_byte(b1);
        bitv(e);
    endtask

    task automatic start_boot(input bit ack);
        expect_ack = ack;
        boot_start = 1'b1;
        cyc(1'b0, 1'b1);
    endtask

    task automatic fresh();
        abort = 1'b1;
        irq_clr = '1;
        cyc(1'b0, 1'b1);
        rx_n = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc(1'b0, 1'b1);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1);
        chk("R1 irq after reset", irq, 0);
        chk("R1 rx_valid after reset", rx_valid, 0);

        // R2/R3/R4: good token then one block
        fresh();
        start_boot(1'b1);
        bitv(1); bitv(1);
        bitv(0); bitv(0); bitv(1); bitv(0); bitv(1);
        chk("R2 good token", irq, 6'b000001);
        bitv(1);
        bitv(0);
        send_byte(8'hA5);
        chk("R4 strobe after last bit", rx_valid, 1);
        chk("R4 byte value MSB first", rx_byte, 8'hA5);
        send_byte(8'h3C);
        bitv(1);
        chk("R4 strobe one cycle", rx_valid, 0);
        chk("R3 data start after good token", irq, 6'b000011);
        chk("R4 byte count", rx_n, 2);
        chk("R4 second byte", rxq[1], 8'h3C);

        // R2/R3: every token pattern with both end bits
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 2; e++) begin
                logic [7:0] b0;
                b0 = 8'(p * 16 + e);
                fresh();
                start_boot(1'b1);
                bitv(1); bitv(0);
                bitv(p[2]); bitv(p[1]); bitv(p[0]);
                bitv(e[0]);
                bitv(1);
                send_block(b0, ~b0, 1'b1);
                chk("R2 token flag per pattern", irq[0], (p == 2 && e == 1) ? 1 : 0);
                chk("R3 data start after any token", irq[1], 1);
                chk("R3 bytes after any token", {rx_n[7:0], rxq[0], rxq[1]}, {8'd2, b0, ~b0});
            end
        end

        // R4: all 256 byte values through one boot
        fresh();
        boot_timeout = '0;
        gap_timeout = '0;
        start_boot(1'b0);
        for (int k = 0; k < 128; k++) begin
            bitv(1);
            send_block(8'(2 * k), 8'(2 * k + 1), 1'b1);
        end
        chk("R4 all bytes count", rx_n, 256);
        for (int k = 0; k < 256; k++) chk("R4 byte sweep", rxq[k], k);
        chk("R3 no-token data start, no errors", irq, 6'b000010);

        // R5 end-bit error, then R6 start-bit error with R10 set-over-clear
        fresh();
        start_boot(1'b0);
        bitv(1);
        send_block(8'h5A, 8'hC3, 1'b0);
        chk("R5 end-bit error flag", irq[3], 1);
        chk("R5 bytes still delivered", {rx_n[7:0], rxq[0], rxq[1]}, {8'd2, 8'h5A, 8'hC3});
        irq_clr = 6'b000100;
        bitv(0);
        chk("R6 low first wait sample / R10 set wins", irq[2], 1);
        bitv(0);
        bitv(1);
        send_block(8'h11, 8'h22, 1'b1);
        chk("R6 block after idle high accepted", {rx_n[7:0], rxq[2], rxq[3]}, {8'd4, 8'h11, 8'h22});
        chk("R6 flags", irq, 6'b001110);
        irq_clr = 6'b000100;
        cyc(1'b0, 1'b1);
        chk("R10 clear one bit only", irq, 6'b001010);

        // R7: first-block timeout at exactly T sampled cycles
        for (int t = 1; t <= 6; t++) begin
            fresh();
            boot_timeout = TW'(t);
            start_boot(1'b0);
            repeat (t - 1) bitv(1);
            chk("R7 no timeout before T", irq[4], 0);
            bitv(1);
            chk("R7 timeout at T", irq[4], 1);
            bitv(1);
            send_block(8'hFF, 8'h00, 1'b1);
            chk("R7 stopped after timeout", {irq[1], rx_n[7:0]}, 0);
        end

        // R9: only sampled cycles count; line ignored without enable
        fresh();
        boot_timeout = 8'd4;
        start_boot(1'b0);
        for (int i = 0; i < 3; i++) begin
            bitv(1);
            repeat (5) cyc(1'b0, 1'b0);
        end
        chk("R9 unsampled cycles not counted", irq, 0);
        bitv(1);
        chk("R9 timeout on 4th sampled cycle", irq[4], 1);

        // R7: zero disables
        fresh();
        boot_timeout = '0;
        start_boot(1'b0);
        repeat (300) bitv(1);
        chk("R7 zero limit disables", irq[4], 0);
        send_block(8'h81, 8'h18, 1'b1);
        chk("R7 zero limit still receives", {irq[1], rx_n[7:0]}, {1'b1, 8'd2});

        // R9: no first-block timeout with a token
        fresh();
        boot_timeout = 8'd3;
        start_boot(1'b1);
        repeat (20) bitv(1);
        chk("R9 no timeout in token mode", irq[4], 0);

        // R8: inter-block timeout
        for (int g = 1; g <= 4; g++) begin
            fresh();
            boot_timeout = '0;
            gap_timeout = TW'(g);
            start_boot(1'b0);
            bitv(1);
            send_block(8'(g), 8'(g + 8), 1'b1);
            repeat (g - 1) bitv(1);
            chk("R8 no gap timeout before G", irq[5], 0);
            bitv(1);
            chk("R8 gap timeout at G", irq[5], 1);
            bitv(1);
            send_block(8'h42, 8'h24, 1'b1);
            chk("R8 block after gap timeout", {rx_n[7:0], rxq[2], rxq[3]}, {8'd4, 8'h42, 8'h24});
        end

        // R11: abort drops partial byte, keeps flags
        fresh();
        gap_timeout = '0;
        start_boot(1'b0);
        bitv(1); bitv(0);
        bitv(1); bitv(0); bitv(1); bitv(1);
        abort = 1'b1;
        cyc(1'b1, 1'b0);
        repeat (10) bitv(1);
        chk("R11 no byte after abort", rx_n, 0);
        chk("R11 flags kept", irq, 6'b000010);
        start_boot(1'b0);
        bitv(1);
        send_block(8'hE7, 8'h7E, 1'b1);
        chk("R11 clean restart", {rx_n[7:0], rxq[0], rxq[1]}, {8'd2, 8'hE7, 8'h7E});

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule